// File: doc/BRIEF.md
# Serial ADC Host Interface Controller

This block is the host-side master for an 8-bit serial successive-approximation converter with a multiplexed analog front end. Running from the system clock, it derives the converter's serial clock by division and frames every conversion with an active-low select. Each frame begins by shifting a start bit and a 4-bit channel-configuration word out to the converter. The block then collects the conversion result twice: once most-significant bit first, then again as the automatic least-significant-bit-first copy. When the frame is over it deasserts select and returns the 8-bit result.

Requests come in on a valid/ready port that carries mode, odd/sign and a 2-bit channel select. Results leave on a valid/ready port together with a mismatch flag, which is set when the two copies disagree. Back-pressure works as follows. A result that has not been taken keeps `res_valid` high and holds `res_data` and `res_mismatch` unchanged. Until the result is taken, `req_ready` stays low. After each frame, select and the serial clock are held high for at least `IDLE_CYC` system clocks, which lets the converter clear its registers. `req_ready` also stays low during that idle time.

With `SHARED_WIRE = 1`, the data-out enable drops once the last address bit is sent, so one wire can carry data both ways. With `SHARED_WIRE = 0`, the host drives the line low after the address.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, `cs_n` = 1, `sclk` = 1, `res_valid` = 0 and `host_do_en` = 0 (shared-wire build).
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while idle, with the idle time elapsed and no result pending. `cs_n` falls on the clock edge that takes the request.
- R3: `cs_n` falls on the same cycle as the first `sclk` fall. A frame has exactly 21 serial clock periods, each a low phase followed by a high phase. Every phase lasts `HALF_DIV` system clocks.
- R4: In serial periods 0..4 the host presents these bits in order: 1 (start), single/differential, odd/sign, select bit 1, select bit 0. Each bit is driven from the falling edge that begins its period and is held through the following rising edge.
- R5: In the shared-wire build, `host_do_en` falls together with `sclk` at the start of period 5 and stays low until the frame ends, so it never overlaps the converter driving the line.
- R6: `host_di` is sampled at the end of each low phase, which is the rising `sclk` edge. The value from period 5 (the leading zero) is discarded. Periods 6..13 give `res_data` bits 7 down to 0.
- R7: Periods 14..20 carry the copy bits 1 through 7 in that order. `res_mismatch` is 1 exactly when this copy differs from `res_data[7:1]`.
- R8: While `res_valid` = 1 and `res_ready` = 0, `res_data` and `res_mismatch` hold steady, `cs_n` stays high and no request is taken. `res_valid` clears on the edge where `res_ready` is sampled high.
- R9: Between frames, and from reset to the first frame, `cs_n` and `sclk` stay high for at least `IDLE_CYC` system clocks.
- R10: `res_valid` rises exactly 42*`HALF_DIV` clock edges after the edge that took the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Request will be taken this cycle |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_odd | input | 1 | Odd channel / polarity swap bit |
| req_sel | input | 2 | Channel select, bit 1 sent first |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DATA_W | Conversion result |
| res_mismatch | output | 1 | Copy disagreed with the primary result |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low converter select |
| host_do | output | 1 | Address data toward the converter |
| host_do_en | output | 1 | Host drives the data line |
| host_di | input | 1 | Data from the converter |

## Verification
The result is due exactly 42*`HALF_DIV` edges after the request is taken. The bench stamps the cycle on which the request was taken, polls `res_valid` at each falling system-clock edge, and checks that the difference between the two stamps matches. The converter model updates its line at the `sclk` fall and the host samples it `HALF_DIV` cycles later. Phase lengths, address bits and release of the line are checked on the serial edges as they happen, at the falling system-clock edge. Back-pressure is checked on every held cycle, and the result must clear one edge after `res_ready` is raised.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } link_state_t;

  typedef struct packed {
    logic       single;
    logic       odd;
    logic [1:0] sel;
  } chan_cfg_t;

  // start bit plus four configuration bits
  localparam int unsigned ADDR_BITS = 5;
  // one leading zero before the result
  localparam int unsigned LEAD_BITS = 1;
endpackage

// File: rtl/adc_host_phase_timer.sv
module adc_host_phase_timer #(
  parameter int unsigned HALF_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign half_end = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || half_end) cnt <= '0;
    else                       cnt <= cnt + CW'(1);
  end

  // R3: phase counter never passes the half-period length
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < (CW+1)'(HALF_DIV));
endmodule

// File: rtl/adc_host_gap_timer.sv
module adc_host_gap_timer #(
  parameter int unsigned IDLE_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic done
);
  localparam int unsigned CW = $clog2(IDLE_CYC + 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= CW'(IDLE_CYC);
    else if (reload)  cnt <= CW'(IDLE_CYC);
    else if (!done)   cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/adc_host_tx.sv
module adc_host_tx
  import adc_host_pkg::*;
#(
  parameter bit          SHARED_WIRE = 1'b1,
  parameter int unsigned PW          = 5
) (
  input  link_state_t     state,
  input  logic [PW-1:0]   pidx,
  input  chan_cfg_t       cfg,
  output logic            host_do,
  output logic            host_do_en
);
  logic [ADDR_BITS-1:0] word;
  logic [ADDR_BITS-1:0] shifted;
  logic                 in_addr;

  assign word    = {1'b1, cfg.single, cfg.odd, cfg.sel};
  assign shifted = word << pidx;
  assign in_addr = (state != ST_IDLE) && (pidx < PW'(ADDR_BITS));
  assign host_do = in_addr ? shifted[ADDR_BITS-1] : 1'b0;

  generate
    if (SHARED_WIRE) begin : g_shared
      assign host_do_en = in_addr;
    end else begin : g_split
      assign host_do_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/adc_host_rx.sv
module adc_host_rx
  import adc_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [PW-1:0]     pidx,
  input  logic              din,
  output logic [DATA_W-1:0] msb_word,
  output logic              copy_ok
);
  localparam int unsigned MSB_FIRST = ADDR_BITS + LEAD_BITS;
  localparam int unsigned MSB_LAST  = MSB_FIRST + DATA_W - 1;
  localparam int unsigned LSB_LAST  = MSB_LAST + DATA_W - 1;

  logic [DATA_W-2:0] copy_word;
  logic              in_msb;
  logic              in_copy;

  assign in_msb  = (pidx >= PW'(MSB_FIRST)) && (pidx <= PW'(MSB_LAST));
  assign in_copy = (pidx >  PW'(MSB_LAST))  && (pidx <= PW'(LSB_LAST));
  assign copy_ok = (copy_word == msb_word[DATA_W-1:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_word  <= '0;
      copy_word <= '0;
    end else if (clear) begin
      msb_word  <= '0;
      copy_word <= '0;
    end else if (sample) begin
      if (in_msb)       msb_word  <= {msb_word[DATA_W-2:0], din};
      else if (in_copy) copy_word <= {din, copy_word[DATA_W-2:1]};
    end
  end
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HALF_DIV    = 64,
  parameter int unsigned IDLE_CYC    = 128,
  parameter bit          SHARED_WIRE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_single,
  input  logic              req_odd,
  input  logic [1:0]        req_sel,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_mismatch,
  output logic              sclk,
  output logic              cs_n,
  output logic              host_do,
  output logic              host_do_en,
  input  logic              host_di
);
  localparam int unsigned FRAME = ADDR_BITS + LEAD_BITS + 2*DATA_W - 1;
  localparam int unsigned PW    = $clog2(FRAME);
  localparam int unsigned LAST  = FRAME - 1;

  link_state_t       state;
  logic [PW-1:0]     pidx;
  chan_cfg_t         cfg;
  logic              half_end;
  logic              gap_done;
  logic              accept;
  logic              frame_end;
  logic              sample;
  logic [DATA_W-1:0] msb_word;
  logic              copy_ok;

  assign sclk      = (state != ST_LOW);
  assign cs_n      = (state == ST_IDLE);
  assign req_ready = (state == ST_IDLE) && gap_done && !res_valid;
  assign accept    = req_valid && req_ready;
  assign sample    = (state == ST_LOW) && half_end;
  assign frame_end = (state == ST_HIGH) && half_end && (pidx == PW'(LAST));

  adc_host_phase_timer #(.HALF_DIV(HALF_DIV)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state != ST_IDLE),
    .half_end (half_end)
  );

  adc_host_gap_timer #(.IDLE_CYC(IDLE_CYC)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (frame_end),
    .done   (gap_done)
  );

  adc_host_tx #(.SHARED_WIRE(SHARED_WIRE), .PW(PW)) u_tx (
    .state      (state),
    .pidx       (pidx),
    .cfg        (cfg),
    .host_do    (host_do),
    .host_do_en (host_do_en)
  );

  adc_host_rx #(.DATA_W(DATA_W), .PW(PW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .sample   (sample),
    .pidx     (pidx),
    .din      (host_di),
    .msb_word (msb_word),
    .copy_ok  (copy_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pidx  <= '0;
      cfg   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_LOW;
          pidx  <= '0;
          cfg   <= '{single: req_single, odd: req_odd, sel: req_sel};
        end
        ST_LOW: if (half_end) state <= ST_HIGH;
        ST_HIGH: if (half_end) begin
          if (pidx == PW'(LAST)) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_LOW;
            pidx  <= pidx + PW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_mismatch <= 1'b0;
    end else if (frame_end) begin
      res_valid    <= 1'b1;
      res_data     <= msb_word;
      res_mismatch <= !copy_ok;
    end else if (res_valid && res_ready) begin
      res_valid    <= 1'b0;
    end
  end

  // R2: ready only while the link is idle and nothing is pending
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && sclk && !res_valid));

  // R3: select and serial clock fall together at frame start
  p_cs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $fell(sclk));

  // R8: pending result is held unchanged under back-pressure
  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_mismatch)));

  // R8: no frame runs while a result waits
  p_pending_no_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cs_n);

  // R9: serial clock parked high whenever select is high
  p_idle_clock_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  generate
    if (SHARED_WIRE) begin : g_release_chk
      // R5: line released only at a serial clock fall inside a frame
      p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_do_en) |-> ($fell(sclk) && !cs_n));
    end
  endgenerate
endmodule

// File: tb/adc_serial_host_bench.sv
module adc_serial_host_bench;
  localparam int H      = 64;
  localparam int IDLE   = 128;
  localparam int DW     = 8;
  localparam int FRAMEP = 21;
  localparam int LAT    = 2 * H * FRAMEP;
  localparam int NCONV  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_single = 1'b0;
  logic          req_odd = 1'b0;
  logic [1:0]    req_sel = 2'b00;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [DW-1:0] res_data;
  logic          res_mismatch;
  logic          sclk, cs_n, host_do, host_do_en, host_di;

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model state
  logic          mdl_en = 1'b0;
  logic          mdl_bit = 1'b0;
  logic [DW-1:0] m_val = '0;
  logic          m_corrupt = 1'b0;
  int            m_cbit = 1;
  logic [4:0]    exp_word = '0;

  assign host_di = mdl_en ? mdl_bit : (host_do_en ? host_do : 1'b0);

  adc_serial_host #(.DATA_W(DW), .HALF_DIV(H), .IDLE_CYC(IDLE), .SHARED_WIRE(1'b1)) u_adc_serial_host (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_single(req_single), .req_odd(req_odd), .req_sel(req_sel),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_mismatch(res_mismatch),
    .sclk(sclk), .cs_n(cs_n), .host_do(host_do), .host_do_en(host_do_en),
    .host_di(host_di)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model of the converter plus protocol observation
  logic       prev_sclk = 1'b1;
  logic       prev_cs   = 1'b1;
  int         rcount = 0;
  int         fcount = 0;
  int         ph_len = 0;
  int         idle_len = 0;
  logic [4:0] rx_word = '0;

  task automatic on_fall();
    int p;
    p = fcount;
    fcount++;
    if (p == 5) chk(!host_do_en, "R5 line released at period 5", host_do_en, 0);
    if (p >= 5) begin
      mdl_en = 1'b1;
      if (p >= 6 && p <= 13)       mdl_bit = m_val[13 - p];
      else if (p >= 14 && p <= 20) mdl_bit = m_val[p - 13] ^ (m_corrupt && (p - 13) == m_cbit);
      else                         mdl_bit = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mdl_en = 1'b0; rcount = 0; fcount = 0; ph_len = 0; idle_len = 0;
      prev_sclk = 1'b1; prev_cs = 1'b1;
    end else begin
      if (cs_n) begin
        if (!prev_cs) begin
          chk(sclk, "R9 clock high at frame end", sclk, 1);
          chk(rx_word == exp_word, "R4 address word", rx_word, exp_word);
          chk(fcount == FRAMEP, "R3 serial periods per frame", fcount, FRAMEP);
          idle_len = 0;
        end
        if (!sclk) chk(0, "R9 clock low while idle", sclk, 1);
        idle_len++;
        mdl_en = 1'b0; rcount = 0; fcount = 0; ph_len = 0;
      end else begin
        if (prev_cs) begin
          chk(!sclk, "R3 clock falls with select", sclk, 0);
          chk(idle_len >= IDLE, "R9 idle length", idle_len, IDLE);
          ph_len = 1;
          on_fall();
        end else if (sclk != prev_sclk) begin
          chk(ph_len == H, "R3 phase length", ph_len, H);
          ph_len = 1;
          if (sclk) begin
            if (rcount < 5) begin
              rx_word = {rx_word[3:0], host_do && host_do_en};
              rcount++;
            end
          end else begin
            on_fall();
          end
        end else begin
          ph_len++;
        end
        if (mdl_en && host_do_en) chk(0, "R5 line contention", host_do_en, 0);
      end
      prev_sclk = sclk;
      prev_cs   = cs_n;
    end
  end

  task automatic run_one(input logic [DW-1:0] val, input bit corrupt, input int cbit,
                         input logic sgl, input logic odd, input logic [1:0] sel);
    longint a_cyc;
    int     waited;
    int     hold;
    logic [DW-1:0] held;
    m_val = val; m_corrupt = corrupt; m_cbit = cbit;
    exp_word = {1'b1, sgl, odd, sel};
    @(negedge clk);
    req_single = sgl; req_odd = odd; req_sel = sel; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    a_cyc = cyc;
    chk(!cs_n, "R2 frame starts on acceptance", cs_n, 0);
    waited = 0;
    while (!res_valid && waited < LAT + 10) begin
      @(negedge clk);
      waited++;
    end
    chk(res_valid && (cyc - a_cyc) == LAT, "R10 result latency", cyc - a_cyc, LAT);
    chk(res_data == val, "R6 result value", res_data, val);
    chk(res_mismatch == corrupt, "R7 mismatch flag", res_mismatch, corrupt);
    held = res_data;
    hold = 1 + int'($urandom % 5);
    req_valid = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(res_valid && res_data == held && res_mismatch == corrupt, "R8 result held", res_data, held);
      chk(cs_n && !req_ready, "R8 no request taken while pending", cs_n, 1);
    end
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R8 result released", res_valid, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n, "R1 select high after reset", cs_n, 1);
    chk(sclk, "R1 clock high after reset", sclk, 1);
    chk(!res_valid, "R1 no result after reset", res_valid, 0);
    chk(!host_do_en, "R1 line not driven after reset", host_do_en, 0);
    repeat (IDLE / 2) @(negedge clk);
    chk(!req_ready, "R9 not ready before idle time", req_ready, 0);
    for (int n = 0; n < NCONV; n++) begin
      case (n)
        0: run_one(8'h00, 1'b0, 1, 1'b1, 1'b0, 2'b00);
        1: run_one(8'hFF, 1'b0, 1, 1'b0, 1'b1, 2'b11);
        2: run_one(8'hA5, 1'b1, 1, 1'b1, 1'b1, 2'b10);
        3: run_one(8'h5A, 1'b1, 7, 1'b0, 1'b0, 2'b01);
        default: run_one(DW'($urandom), ($urandom % 3) == 0, 1 + int'($urandom % 7),
                         1'($urandom), 1'($urandom), 2'($urandom));
      endcase
    end
    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule